// File: doc/BRIEF.md
# Programmable Sum-of-Products Logic Array

This block is the logic plane of a small programmable logic core. Twelve dedicated input signals and ten feedback signals each produce a true line and a complement line. Every product term is an AND over the lines whose connection bit is set. Each of ten outputs takes an OR over a group of these terms, and the groups differ in size. Further terms give a per-output enable, a global preset, a global clear and a clock term. Macrocells, pins and tri-state buffers lie outside this block and use these results.

The connection bits are loaded one bit per clock through a serial port while a load enable is held. They fill one 44-bit term row at a time. A bulk-erase command opens every connection. A done strobe makes the loaded pattern live. Until that strobe, during loading and after an erase, every term output shows the erased value, which is constant true. The configuration controller has three states. `ST_BLANK` is the state after reset or erase, with outputs forced true. `ST_SHIFT` is the state while rows are loaded, with outputs forced true. `ST_LIVE` is the state in which the array is evaluated. Erase takes any state to `ST_BLANK`. Done takes any state to `ST_LIVE`. Load enable, with no erase and no done, takes any state to `ST_SHIFT`. With none of these, the state holds.

Top module: `sop_array`

## Requirements
- R1: Signal index s is `ded_i[s]` for s = 0..11 and `fb_i[s-12]` for s = 12..21. Line 2s carries signal s and line 2s+1 carries its complement, for 44 lines in all.
- R2: A live product term is the AND of every line whose connection bit is 1. A term with all bits 0 (all open) is constant 1.
- R3: A term connected to both the true and the complement line of one signal is constant 0.
- R4: Term rows 0..119 form the sums. Output k (0..9) takes consecutive rows with group sizes 8, 10, 12, 14, 16, 16, 14, 12, 10, 8, starting at row 0. `sum_o[k]` is the OR of its group, so rows with every bit set add nothing.
- R5: Row 120+k drives `oe_o[k]`, row 130 drives `preset_o`, row 131 drives `clear_o` and row 132 drives `clk_term_o`. An enable row that is all open gives 1, and one that is all connected gives 0.
- R6: While `cfg_load_en` is 1, one `cfg_bit` is taken at each rising clock edge. The first bit of a row is line 0. Each 44 bits complete one row. Each loading session, begun from a state other than `ST_SHIFT`, starts again at row 0. Rows that are not reloaded keep their contents.
- R7: In `ST_SHIFT` every term output is 1.
- R8: A `cfg_done` pulse puts the block in `ST_LIVE` from the next clock edge. In `ST_LIVE` the outputs follow the stored pattern.
- R9: `cfg_erase` sets every connection bit to 0 and enters `ST_BLANK`. From the next edge all outputs are 1, and after a later done strobe they remain 1 for any inputs.
- R10: After reset the block is in `ST_BLANK` with all connections open, and every output is 1.
- R11: In `ST_LIVE` the path from the inputs to the outputs is purely combinational.
- R12: When commands arrive together, erase wins over done, and done wins over load enable.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Configuration clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_erase | input | 1 | Bulk erase command |
| cfg_load_en | input | 1 | Serial load enable |
| cfg_bit | input | 1 | Serial connection bit |
| cfg_done | input | 1 | Done strobe that makes the pattern live |
| ded_i | input | 12 | Dedicated input signals |
| fb_i | input | 10 | Feedback signals |
| sum_o | output | 10 | OR of each output's term group |
| oe_o | output | 10 | Per-output enable terms |
| preset_o | output | 1 | Global synchronous preset term |
| clear_o | output | 1 | Global asynchronous clear term |
| clk_term_o | output | 1 | Clock product term |

## Verification
The data inputs reach every output within the same cycle, so each comparison against the reference evaluation is sampled 1 ns after the inputs change, with no clock edge in between. Configuration commands act at a rising edge. Results that depend on a command (the forced-true outputs after erase or load enable, and the live outputs after done) are therefore sampled at the falling edge after the edge that took the command. The last bit of a row is stored at the edge that takes it. The bench drives every command at a falling edge and reads the outputs only at later falling edges or 1 ns after an input change.

// File: rtl/sop_pkg.sv
package sop_pkg;

    typedef enum logic [1:0] {
        ST_BLANK = 2'd0,
        ST_SHIFT = 2'd1,
        ST_LIVE  = 2'd2
    } cfg_state_e;

    // Group size of output k: grows by step up to the midpoint, then mirrors.
    function automatic int grp_size(input int k, input int n_out,
                                    input int min_g, input int step);
        if (k < n_out / 2)
            return min_g + step * k;
        else
            return min_g + step * (n_out - 1 - k);
    endfunction

    // First term row of output k (k == n_out gives the total sum-term count).
    function automatic int grp_base(input int k, input int n_out,
                                    input int min_g, input int step);
        int acc;
        acc = 0;
        for (int j = 0; j < k; j++)
            acc += grp_size(j, n_out, min_g, step);
        return acc;
    endfunction

endpackage

// File: rtl/sop_cfg_loader.sv
module sop_cfg_loader
    import sop_pkg::*;
#(
    parameter int N_LINE = 44,
    parameter int N_TERM = 133
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic                           cfg_erase,
    input  logic                           cfg_load_en,
    input  logic                           cfg_bit,
    input  logic                           cfg_done,
    output logic [N_TERM-1:0][N_LINE-1:0]  conn_o,
    output logic                           live_o
);
    localparam int CW = $clog2(N_LINE);
    localparam int PW = $clog2(N_TERM + 1);
    localparam logic [CW-1:0] CNT_LAST = CW'(N_LINE - 1);
    localparam logic [PW-1:0] PTR_END  = PW'(N_TERM);

    cfg_state_e state_q, state_d;

    logic [N_TERM-1:0][N_LINE-1:0] conn_q;
    logic [N_LINE-1:0]             sr_q;
    logic [CW-1:0]                 cnt_q;
    logic [PW-1:0]                 ptr_q;

    logic [CW-1:0]     cnt_eff;
    logic [PW-1:0]     ptr_eff;
    logic [N_LINE-1:0] row_next;

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            state_q <= ST_BLANK;
        else
            state_q <= state_d;
    end

    // Next state: erase beats done, done beats load enable
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_BLANK, ST_SHIFT, ST_LIVE: begin
                if (cfg_erase)
                    state_d = ST_BLANK;
                else if (cfg_done)
                    state_d = ST_LIVE;
                else if (cfg_load_en)
                    state_d = ST_SHIFT;
            end
            default: state_d = ST_BLANK;
        endcase
    end

    // A new session restarts bit and row counting
    always_comb begin
        cnt_eff  = (state_q == ST_SHIFT) ? cnt_q : '0;
        ptr_eff  = (state_q == ST_SHIFT) ? ptr_q : '0;
        row_next = {cfg_bit, sr_q[N_LINE-1:1]};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            conn_q <= '0;
            sr_q   <= '0;
            cnt_q  <= '0;
            ptr_q  <= '0;
        end else if (cfg_erase) begin
            conn_q <= '0;
            cnt_q  <= '0;
            ptr_q  <= '0;
        end else if (cfg_load_en) begin
            sr_q <= row_next;
            if (cnt_eff == CNT_LAST) begin
                cnt_q <= '0;
                if (ptr_eff < PTR_END) begin
                    conn_q[ptr_eff] <= row_next;
                    ptr_q           <= ptr_eff + 1'b1;
                end else begin
                    ptr_q <= ptr_eff;
                end
            end else begin
                cnt_q <= cnt_eff + 1'b1;
                ptr_q <= ptr_eff;
            end
        end
    end

    // Outputs
    always_comb begin
        conn_o = conn_q;
        live_o = (state_q == ST_LIVE);
    end

endmodule

// File: rtl/sop_term_plane.sv
module sop_term_plane #(
    parameter int N_DED  = 12,
    parameter int N_FB   = 10,
    parameter int N_TERM = 133,
    localparam int N_SIG  = N_DED + N_FB,
    localparam int N_LINE = 2 * N_SIG
) (
    input  logic [N_DED-1:0]               ded_i,
    input  logic [N_FB-1:0]                fb_i,
    input  logic [N_TERM-1:0][N_LINE-1:0]  conn_i,
    input  logic                           live_i,
    output logic [N_TERM-1:0]              term_o
);
    logic [N_SIG-1:0]  sig;
    logic [N_LINE-1:0] lines;

    assign sig = {fb_i, ded_i};

    for (genvar s = 0; s < N_SIG; s++) begin : g_line
        assign lines[2*s]   = sig[s];
        assign lines[2*s+1] = ~sig[s];
    end

    // Open connections read as 1; an unarmed array shows the erased value.
    for (genvar t = 0; t < N_TERM; t++) begin : g_term
        assign term_o[t] = ~live_i | (&(lines | ~conn_i[t]));
    end

endmodule

// File: rtl/sop_or_plane.sv
module sop_or_plane
    import sop_pkg::*;
#(
    parameter int N_OUT    = 10,
    parameter int MIN_GRP  = 8,
    parameter int GRP_STEP = 2,
    localparam int N_SUM  = grp_base(N_OUT, N_OUT, MIN_GRP, GRP_STEP),
    localparam int N_TERM = N_SUM + N_OUT + 3
) (
    input  logic [N_TERM-1:0] term_i,
    output logic [N_OUT-1:0]  sum_o,
    output logic [N_OUT-1:0]  oe_o,
    output logic              preset_o,
    output logic              clear_o,
    output logic              clk_term_o
);
    for (genvar k = 0; k < N_OUT; k++) begin : g_sum
        localparam int BASE = grp_base(k, N_OUT, MIN_GRP, GRP_STEP);
        localparam int SIZE = grp_size(k, N_OUT, MIN_GRP, GRP_STEP);
        assign sum_o[k] = |term_i[BASE+SIZE-1:BASE];
        assign oe_o[k]  = term_i[N_SUM+k];
    end

    assign preset_o   = term_i[N_SUM+N_OUT];
    assign clear_o    = term_i[N_SUM+N_OUT+1];
    assign clk_term_o = term_i[N_SUM+N_OUT+2];

endmodule

// File: rtl/sop_array.sv
module sop_array
    import sop_pkg::*;
#(
    parameter int N_DED    = 12,
    parameter int N_FB     = 10,
    parameter int N_OUT    = 10,
    parameter int MIN_GRP  = 8,
    parameter int GRP_STEP = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cfg_erase,
    input  logic             cfg_load_en,
    input  logic             cfg_bit,
    input  logic             cfg_done,
    input  logic [N_DED-1:0] ded_i,
    input  logic [N_FB-1:0]  fb_i,
    output logic [N_OUT-1:0] sum_o,
    output logic [N_OUT-1:0] oe_o,
    output logic             preset_o,
    output logic             clear_o,
    output logic             clk_term_o
);
    localparam int N_LINE = 2 * (N_DED + N_FB);
    localparam int N_SUM  = grp_base(N_OUT, N_OUT, MIN_GRP, GRP_STEP);
    localparam int N_TERM = N_SUM + N_OUT + 3;

    logic [N_TERM-1:0][N_LINE-1:0] conn_w;
    logic                          live_w;
    logic [N_TERM-1:0]             term_w;

    sop_cfg_loader #(
        .N_LINE (N_LINE),
        .N_TERM (N_TERM)
    ) i_loader (
        .clk         (clk),
        .rst_n       (rst_n),
        .cfg_erase   (cfg_erase),
        .cfg_load_en (cfg_load_en),
        .cfg_bit     (cfg_bit),
        .cfg_done    (cfg_done),
        .conn_o      (conn_w),
        .live_o      (live_w)
    );

    sop_term_plane #(
        .N_DED  (N_DED),
        .N_FB   (N_FB),
        .N_TERM (N_TERM)
    ) i_terms (
        .ded_i  (ded_i),
        .fb_i   (fb_i),
        .conn_i (conn_w),
        .live_i (live_w),
        .term_o (term_w)
    );

    sop_or_plane #(
        .N_OUT    (N_OUT),
        .MIN_GRP  (MIN_GRP),
        .GRP_STEP (GRP_STEP)
    ) i_or (
        .term_i     (term_w),
        .sum_o      (sum_o),
        .oe_o       (oe_o),
        .preset_o   (preset_o),
        .clear_o    (clear_o),
        .clk_term_o (clk_term_o)
    );

endmodule

// File: rtl/sop_array_chk.sv
module sop_array_chk #(
    parameter int N_OUT = 10
) (
    input logic             clk,
    input logic             rst_n,
    input logic             cfg_erase,
    input logic             cfg_load_en,
    input logic             cfg_done,
    input logic [N_OUT-1:0] sum_o,
    input logic [N_OUT-1:0] oe_o,
    input logic             preset_o,
    input logic             clear_o,
    input logic             clk_term_o,
    input logic             live
);
    logic all_true;
    assign all_true = (&sum_o) && (&oe_o) && preset_o && clear_o && clk_term_o;

    // R9: the cycle after an erase every output shows the erased value
    a_r9_erase_blanks: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_erase |=> all_true);

    // R7: loading without erase or done forces every output true
    a_r7_load_forces_true: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_load_en && !cfg_done && !cfg_erase) |=> all_true);

    // R8: done without erase makes the array live
    a_r8_done_arms: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_done && !cfg_erase) |=> live);

    // R12: erase wins over done
    a_r12_erase_over_done: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_erase |=> !live);

    // R8: a live array stays live while no command arrives
    a_r8_live_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (live && !cfg_erase && !cfg_load_en) |=> live);

    // R10: not live means erased outputs
    a_r10_idle_true: assert property (@(posedge clk) disable iff (!rst_n)
        !live |-> all_true);

endmodule

bind sop_array sop_array_chk #(.N_OUT(N_OUT)) i_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .cfg_erase   (cfg_erase),
    .cfg_load_en (cfg_load_en),
    .cfg_done    (cfg_done),
    .sum_o       (sum_o),
    .oe_o        (oe_o),
    .preset_o    (preset_o),
    .clear_o     (clear_o),
    .clk_term_o  (clk_term_o),
    .live        (live_w)
);

// File: tb/test_sop_array.sv
`timescale 1ns/1ps
module test_sop_array;
    localparam int ND = 12, NF = 10, NO = 10, NL = 44, NS = 120, NT = 133;
    localparam int NV = NO + NO + 3;

    logic clk = 1'b0, rst_n = 1'b0;
    logic cfg_erase = 1'b0, cfg_load_en = 1'b0, cfg_bit = 1'b0, cfg_done = 1'b0;
    logic [ND-1:0] ded_i = '0;
    logic [NF-1:0] fb_i = '0;
    logic [NO-1:0] sum_o, oe_o;
    logic preset_o, clear_o, clk_term_o;

    int checks = 0, failures = 0;
    logic [NL-1:0] conn_m [NT];

    always #5 clk = ~clk;

    sop_array i_sop_array (
        .clk(clk), .rst_n(rst_n), .cfg_erase(cfg_erase), .cfg_load_en(cfg_load_en),
        .cfg_bit(cfg_bit), .cfg_done(cfg_done), .ded_i(ded_i), .fb_i(fb_i),
        .sum_o(sum_o), .oe_o(oe_o), .preset_o(preset_o), .clear_o(clear_o),
        .clk_term_o(clk_term_o)
    );

    function automatic logic [NV-1:0] dut_vec();
        return {clk_term_o, clear_o, preset_o, oe_o, sum_o};
    endfunction

    // Reference term per R1/R2/R3
    function automatic logic ref_term(input int r, input logic [ND-1:0] d, input logic [NF-1:0] f);
        logic res;
        res = 1'b1;
        for (int s = 0; s < ND + NF; s++) begin
            logic v;
            v = (s < ND) ? d[s] : f[s-ND];
            if (conn_m[r][2*s] && !v) res = 1'b0;
            if (conn_m[r][2*s+1] && v) res = 1'b0;
        end
        return res;
    endfunction

    // Reference outputs per R4/R5
    function automatic logic [NV-1:0] ref_vec(input logic [ND-1:0] d, input logic [NF-1:0] f);
        logic [NV-1:0] v;
        int base;
        v = '0;
        base = 0;
        for (int k = 0; k < NO; k++) begin
            int sz;
            sz = (k < 5) ? 8 + 2 * k : 8 + 2 * (9 - k);
            for (int j = 0; j < sz; j++)
                if (ref_term(base + j, d, f)) v[k] = 1'b1;
            base += sz;
            v[NO+k] = ref_term(NS + k, d, f);
        end
        v[2*NO]   = ref_term(NS + NO, d, f);
        v[2*NO+1] = ref_term(NS + NO + 1, d, f);
        v[2*NO+2] = ref_term(NS + NO + 2, d, f);
        return v;
    endfunction

    task automatic check(input string req, input logic [NV-1:0] act, input logic [NV-1:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Shift rows 0..n-1 of the model; optional mid-load check (R7)
    task automatic load_rows(input int n, input bit mid_check);
        for (int r = 0; r < n; r++) begin
            for (int l = 0; l < NL; l++) begin
                @(negedge clk);
                cfg_load_en = 1'b1;
                cfg_bit = conn_m[r][l];
                if (mid_check && r == 60 && l == 0)
                    check("R7 mid-load outputs", dut_vec(), '1);
            end
        end
        @(negedge clk);
        cfg_load_en = 1'b0;
    endtask

    task automatic pulse_done();
        @(negedge clk);
        cfg_done = 1'b1;
        @(negedge clk);
        cfg_done = 1'b0;
    endtask

    task automatic random_vectors(input int n, input string req, input bit directed);
        for (int i = 0; i < n; i++) begin
            ded_i = ND'($urandom);
            fb_i = NF'($urandom);
            #1;
            check(req, dut_vec(), ref_vec(ded_i, fb_i));
            if (directed) begin
                check("R2 sum0 all-open term", {22'd0, sum_o[0]}, 23'd1);
                check("R3/R4 sum1 equals ded0", {22'd0, sum_o[1]}, {22'd0, ded_i[0]});
                check("R3 preset contradiction", {22'd0, preset_o}, 23'd0);
                check("R5 oe0 open, oe1 intact", {21'd0, oe_o[1:0]}, 23'd1);
            end
        end
    endtask

    initial begin
        #1_500_000;
        checks++;
        failures++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        void'($urandom(32'd1234));
        // Sparse random pattern plus directed rows
        for (int r = 0; r < NT; r++) begin
            for (int l = 0; l < NL; l++)
                conn_m[r][l] = (($urandom % 24) == 0);
        end
        conn_m[0] = '0;                        // R2 all-open term in output 0
        conn_m[8] = '0; conn_m[8][0] = 1'b1;   // output 1: ded0 true
        conn_m[9] = '0; conn_m[9][3:2] = 2'b11;// R3 contradiction
        for (int r = 10; r < 18; r++) conn_m[r] = '1; // unused terms
        conn_m[NS]   = '0;                     // oe0 permanently on
        conn_m[NS+1] = '1;                     // oe1 permanently off
        conn_m[NS+NO] = '0; conn_m[NS+NO][1:0] = 2'b11; // preset never

        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        ded_i = 12'hA5A; fb_i = 10'h155; #1;
        check("R10 reset outputs", dut_vec(), '1);

        load_rows(NT, 1'b1);
        pulse_done();
        random_vectors(200, "R1/R8/R11 live evaluation", 1'b1);

        // R6: new session restarts at row 0; other rows kept
        conn_m[1] = '1;
        load_rows(2, 1'b0);
        pulse_done();
        random_vectors(60, "R6 partial reload", 1'b0);

        // R12: done wins over load enable
        @(negedge clk);
        cfg_load_en = 1'b1; cfg_done = 1'b1; cfg_bit = 1'b1;
        @(negedge clk);
        cfg_load_en = 1'b0; cfg_done = 1'b0;
        #1;
        check("R12 done over load", {22'd0, oe_o[1]}, 23'd0);
        // R12: erase wins over done
        cfg_erase = 1'b1; cfg_done = 1'b1;
        @(negedge clk);
        cfg_erase = 1'b0; cfg_done = 1'b0;
        #1;
        check("R12 erase over done", dut_vec(), '1);

        // R9: erase cleared all connections
        for (int r = 0; r < NT; r++) conn_m[r] = '0;
        pulse_done();
        random_vectors(40, "R9 erased array live", 1'b0);
        ded_i = '0; fb_i = '0; #1;
        check("R9 erased all ones", dut_vec(), '1);

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule